// File: doc/BRIEF.md
# Virtual-8086 Mode Transition Controller

This block holds the virtual-8086 (VM) flag and the current privilege level of a 32-bit x86-style core. It decides what happens to that state whenever a mode-relevant event arrives. The core presents single-cycle strobes for four kinds of event: an interrupt or exception, a task switch, an interrupt return, and a flags pop. Alongside each strobe it presents the EFLAGS image involved (the VM bit and privilege of the stacked frame or the incoming task state) and the already decoded descriptor of the gate that an interrupt would use.

The controller lets the core enter VM mode only through a task switch or through an interrupt return issued at privilege 0. It lets the core leave VM mode only through an interrupt that uses a descriptor allowed for that exit. An interrupt with a descriptor that is not allowed raises a one-cycle general-protection pulse, and the mode does not change. Each accepted transition raises a one-cycle accept pulse. The controller also records the VM value that was live when the last interrupt was taken, which the handler uses to tell a V86 caller from a protected-mode caller. Fetching descriptors, accessing the stack and decoding instructions are left to the rest of the core.

Top module: `v86_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves vm=0, cpl=0, saved_vm=0, accept=0 and gp_fault=0.
- R2: An interrupt taken while vm=1 through an allowed descriptor sets vm=0, cpl=0 and saved_vm=1, and pulses accept.
- R3: An exit is allowed only when gate_is32=1 and either gate_kind is 2'b00 (interrupt gate) or 2'b01 (trap gate) with tgt_conforming=0 and tgt_dpl=0, or gate_kind is 2'b10 (task state). Any other interrupt while vm=1 pulses gp_fault and leaves vm, cpl and saved_vm unchanged.
- R4: An interrupt return while vm=0 and cpl=0 with img_vm=1 sets vm=1 and cpl=3, and pulses accept.
- R5: An interrupt return while vm=0 and cpl is not 0 with img_vm=1 changes no state and raises no pulse.
- R6: An interrupt return while vm=0 with img_vm=0 sets cpl to img_cpl, keeps vm=0, and pulses accept.
- R7: A task switch while vm=0 loads vm from img_vm and sets cpl to 3 when img_vm=1, or to img_cpl otherwise, and pulses accept.
- R8: A flags pop never changes vm, cpl or saved_vm and raises no pulse, whatever img_vm holds.
- R9: While vm=1, only an interrupt can clear vm. A task switch pulses gp_fault with no state change, and an interrupt return changes no state and raises no pulse.
- R10: When several strobes are high in the same cycle, only one is acted on. The order of precedence is interrupt, then task switch, then interrupt return, then flags pop.
- R11: An interrupt taken while vm=0 keeps vm=0, sets cpl to tgt_dpl and saved_vm to 0, and pulses accept, whatever the descriptor holds.
- R12: Strobes are sampled on a rising clock edge, and every output reflects them after that edge. accept and gp_fault are never high together, and while vm=1, cpl is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_intr | input | 1 | Interrupt or exception strobe |
| ev_task | input | 1 | Task switch strobe |
| ev_iret | input | 1 | Interrupt return strobe |
| ev_popf | input | 1 | Flags pop strobe |
| img_vm | input | 1 | VM bit of the stacked or task-state EFLAGS image |
| img_cpl | input | 2 | Privilege level carried by the stacked frame or the incoming task |
| gate_kind | input | 2 | 00 interrupt gate, 01 trap gate, 10 task state, 11 other |
| gate_is32 | input | 1 | Descriptor is the 32-bit form |
| tgt_conforming | input | 1 | Target code segment is conforming |
| tgt_dpl | input | 2 | Descriptor privilege level of the target segment |
| vm | output | 1 | Live VM flag |
| cpl | output | 2 | Current privilege level |
| saved_vm | output | 1 | VM value recorded at the last accepted interrupt |
| accept | output | 1 | One-cycle pulse for an accepted transition |
| gp_fault | output | 1 | One-cycle pulse for a refused exit or task switch from VM mode |

## Verification
A corrupted VM or privilege register appears on vm or cpl one cycle after the edge that produced it. It then persists, and the per-cycle comparison against the bench model reports it at once. A wrong exit-legality decision shows as a swapped accept or gp_fault pulse on the cycle after the interrupt strobe, together with a vm value that differs from the model. A fault in the precedence logic shows only when strobes collide, so the random stimulus raises several strobes together often, and directed cases cover the collisions that matter inside and outside VM mode.

// File: rtl/v86_pkg.sv
package v86_pkg;

    localparam int PL_W = 2;
    localparam logic [PL_W-1:0] PL_KERNEL = '0;
    localparam logic [PL_W-1:0] PL_USER   = '1;

    typedef enum logic [1:0] {
        GK_INTR  = 2'b00,
        GK_TRAP  = 2'b01,
        GK_TSS   = 2'b10,
        GK_OTHER = 2'b11
    } gate_kind_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_INTR,
        EV_TASK,
        EV_IRET,
        EV_POPF
    } event_e;

    typedef struct packed {
        gate_kind_e        kind;
        logic              is32;
        logic              conforming;
        logic [PL_W-1:0]   dpl;
    } gate_desc_t;

    typedef struct packed {
        logic              vm;
        logic [PL_W-1:0]   cpl;
        logic              saved_vm;
    } mode_state_t;

    function automatic logic exit_gate_ok(gate_desc_t g);
        logic via_gate;
        via_gate = (g.kind == GK_INTR || g.kind == GK_TRAP)
                   && !g.conforming && (g.dpl == PL_KERNEL);
        return g.is32 && (via_gate || g.kind == GK_TSS);
    endfunction

endpackage

// File: rtl/v86_event_arbiter.sv
module v86_event_arbiter
    import v86_pkg::*;
#(
    parameter int N_EV = 4
) (
    input  logic [N_EV-1:0] strobes,
    output event_e          winner
);
    localparam event_e ORDER [4] = '{EV_INTR, EV_TASK, EV_IRET, EV_POPF};

    logic [N_EV-1:0] grant;

    generate
        for (genvar i = 0; i < N_EV; i++) begin : g_pri
            if (i == 0) begin : g_top
                assign grant[i] = strobes[i];
            end else begin : g_rest
                assign grant[i] = strobes[i] && (strobes[i-1:0] == '0);
            end
        end
    endgenerate

    always_comb begin
        winner = EV_NONE;
        for (int i = 0; i < N_EV; i++) begin
            if (grant[i]) winner = ORDER[i];
        end
    end
endmodule

// File: rtl/v86_transition.sv
module v86_transition
    import v86_pkg::*;
(
    input  event_e          ev,
    input  mode_state_t     cur,
    input  logic            img_vm,
    input  logic [PL_W-1:0] img_cpl,
    input  gate_desc_t      gate,
    output mode_state_t     nxt,
    output logic            acc,
    output logic            gp
);
    logic exit_ok;
    assign exit_ok = exit_gate_ok(gate);

    always_comb begin
        nxt = cur;
        acc = 1'b0;
        gp  = 1'b0;
        unique case (ev)
            EV_INTR: begin
                if (cur.vm) begin
                    if (exit_ok) begin
                        nxt.vm       = 1'b0;
                        nxt.cpl      = PL_KERNEL;
                        nxt.saved_vm = 1'b1;
                        acc          = 1'b1;
                    end else begin
                        gp = 1'b1;
                    end
                end else begin
                    nxt.cpl      = gate.dpl;
                    nxt.saved_vm = 1'b0;
                    acc          = 1'b1;
                end
            end
            EV_TASK: begin
                if (cur.vm) begin
                    gp = 1'b1;
                end else begin
                    nxt.vm  = img_vm;
                    nxt.cpl = img_vm ? PL_USER : img_cpl;
                    acc     = 1'b1;
                end
            end
            EV_IRET: begin
                if (!cur.vm) begin
                    if (!img_vm) begin
                        nxt.cpl = img_cpl;
                        acc     = 1'b1;
                    end else if (cur.cpl == PL_KERNEL) begin
                        nxt.vm  = 1'b1;
                        nxt.cpl = PL_USER;
                        acc     = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/v86_mode_ctrl.sv
module v86_mode_ctrl
    import v86_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ev_intr,
    input  logic            ev_task,
    input  logic            ev_iret,
    input  logic            ev_popf,
    input  logic            img_vm,
    input  logic [1:0]      img_cpl,
    input  logic [1:0]      gate_kind,
    input  logic            gate_is32,
    input  logic            tgt_conforming,
    input  logic [1:0]      tgt_dpl,
    output logic            vm,
    output logic [1:0]      cpl,
    output logic            saved_vm,
    output logic            accept,
    output logic            gp_fault
);
    event_e      ev_sel;
    gate_desc_t  gate;
    mode_state_t cur_q, nxt_d;
    logic        acc_d, gp_d;

    assign gate = '{kind: gate_kind_e'(gate_kind), is32: gate_is32,
                    conforming: tgt_conforming, dpl: tgt_dpl};

    v86_event_arbiter #(.N_EV(4)) u_arb (
        .strobes ({ev_popf, ev_iret, ev_task, ev_intr}),
        .winner  (ev_sel)
    );

    v86_transition u_trans (
        .ev      (ev_sel),
        .cur     (cur_q),
        .img_vm  (img_vm),
        .img_cpl (img_cpl),
        .gate    (gate),
        .nxt     (nxt_d),
        .acc     (acc_d),
        .gp      (gp_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '{vm: 1'b0, cpl: PL_KERNEL, saved_vm: 1'b0};
            accept   <= 1'b0;
            gp_fault <= 1'b0;
        end else begin
            cur_q    <= nxt_d;
            accept   <= acc_d;
            gp_fault <= gp_d;
        end
    end

    assign vm       = cur_q.vm;
    assign cpl      = cur_q.cpl;
    assign saved_vm = cur_q.saved_vm;
endmodule

// File: rtl/v86_mode_ctrl_sva.sv
module v86_mode_ctrl_sva (
    input logic       clk,
    input logic       rst,
    input logic       ev_intr,
    input logic       ev_task,
    input logic       ev_iret,
    input logic       ev_popf,
    input logic       img_vm,
    input logic [1:0] cpl,
    input logic       vm,
    input logic       saved_vm,
    input logic       accept,
    input logic       gp_fault
);
    p_excl_pulses_r12: assert property (@(posedge clk) disable iff (rst)
        !(accept && gp_fault));

    p_v86_user_r12: assert property (@(posedge clk) disable iff (rst)
        vm |-> cpl == 2'd3);

    p_exit_only_intr_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(vm) |-> $past(ev_intr));

    p_exit_kernel_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(vm) |-> (cpl == 2'd0 && accept && saved_vm));

    p_gp_holds_vm_r3: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> (vm && $past(vm)));

    p_entry_rules_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(vm) |-> ($past(ev_task) ||
                       ($past(ev_iret) && $past(cpl) == 2'd0 && $past(img_vm))));

    p_popf_noop_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_popf && !ev_intr && !ev_task && !ev_iret)
        |=> ($stable(vm) && $stable(cpl) && $stable(saved_vm) && !accept && !gp_fault));
endmodule

bind v86_mode_ctrl v86_mode_ctrl_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .ev_intr  (ev_intr),
    .ev_task  (ev_task),
    .ev_iret  (ev_iret),
    .ev_popf  (ev_popf),
    .img_vm   (img_vm),
    .cpl      (cpl),
    .vm       (vm),
    .saved_vm (saved_vm),
    .accept   (accept),
    .gp_fault (gp_fault)
);

// File: tb/v86_mode_ctrl_bench.sv
module v86_mode_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic       clk = 1'b0;
    logic       rst;
    logic       ev_intr, ev_task, ev_iret, ev_popf;
    logic       img_vm;
    logic [1:0] img_cpl, gate_kind, tgt_dpl;
    logic       gate_is32, tgt_conforming;
    logic       vm, saved_vm, accept, gp_fault;
    logic [1:0] cpl;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic       m_vm, m_saved;
    logic [1:0] m_cpl;

    always #(CLK_PERIOD/2) clk = ~clk;

    v86_mode_ctrl u_v86_mode_ctrl (
        .clk(clk), .rst(rst),
        .ev_intr(ev_intr), .ev_task(ev_task), .ev_iret(ev_iret), .ev_popf(ev_popf),
        .img_vm(img_vm), .img_cpl(img_cpl), .gate_kind(gate_kind),
        .gate_is32(gate_is32), .tgt_conforming(tgt_conforming), .tgt_dpl(tgt_dpl),
        .vm(vm), .cpl(cpl), .saved_vm(saved_vm), .accept(accept), .gp_fault(gp_fault)
    );

    function automatic bit exit_allowed(logic [1:0] k, logic w32, logic c, logic [1:0] d);
        if (!w32) return 0;
        if (k == 2'b10) return 1;
        return (k == 2'b00 || k == 2'b01) && !c && d == 2'd0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(logic i, logic t, logic r, logic p, logic iv, logic [1:0] ic,
                        logic [1:0] k, logic w32, logic c, logic [1:0] d);
        logic e_acc, e_gp;
        string req;
        ev_intr = i; ev_task = t; ev_iret = r; ev_popf = p;
        img_vm = iv; img_cpl = ic; gate_kind = k; gate_is32 = w32;
        tgt_conforming = c; tgt_dpl = d;
        e_acc = 0; e_gp = 0; req = "R8";
        if (i) begin
            if (m_vm) begin
                if (exit_allowed(k, w32, c, d)) begin
                    m_vm = 0; m_cpl = 0; m_saved = 1; e_acc = 1; req = "R2";
                end else begin
                    e_gp = 1; req = "R3";
                end
            end else begin
                m_cpl = d; m_saved = 0; e_acc = 1; req = "R11";
            end
        end else if (t) begin
            if (m_vm) begin
                e_gp = 1; req = "R9";
            end else begin
                m_vm = iv; m_cpl = iv ? 2'd3 : ic; e_acc = 1; req = "R7";
            end
        end else if (r) begin
            if (m_vm) req = "R9";
            else if (!iv) begin m_cpl = ic; e_acc = 1; req = "R6"; end
            else if (m_cpl == 0) begin m_vm = 1; m_cpl = 3; e_acc = 1; req = "R4"; end
            else req = "R5";
        end
        if (int'(i) + int'(t) + int'(r) + int'(p) > 1) req = {req, "/R10"};
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(req, "vm", vm, m_vm);
        check(req, "cpl", cpl, m_cpl);
        check(req, "saved_vm", saved_vm, m_saved);
        check(req, "accept", accept, e_acc);
        check(req, "gp_fault", gp_fault, e_gp);
        check("R12", "pulse exclusivity", accept && gp_fault, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1;
        {ev_intr, ev_task, ev_iret, ev_popf, img_vm, gate_is32, tgt_conforming} = '0;
        img_cpl = 0; gate_kind = 0; tgt_dpl = 0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst = 0;
        m_vm = 0; m_cpl = 0; m_saved = 0;
        // R1 reset state
        check("R1", "vm", vm, 0);
        check("R1", "cpl", cpl, 0);
        check("R1", "saved_vm", saved_vm, 0);
        check("R1", "accept", accept, 0);
        check("R1", "gp_fault", gp_fault, 0);

        // directed corner cases
        step(0,1,0,0, 1,2'd0, 2'b00,1,0,2'd0);   // R7 task into V86
        step(0,0,0,1, 0,2'd0, 2'b00,1,0,2'd0);   // R8 popf with VM=0 image
        step(0,0,1,0, 0,2'd0, 2'b00,1,0,2'd0);   // R9 iret inside V86
        step(0,1,0,0, 0,2'd1, 2'b00,1,0,2'd0);   // R9 task inside V86 refused
        step(1,0,0,0, 0,2'd0, 2'b00,0,0,2'd0);   // R3 16-bit gate
        step(1,0,0,0, 0,2'd0, 2'b01,1,1,2'd0);   // R3 conforming target
        step(1,0,0,0, 0,2'd0, 2'b00,1,0,2'd3);   // R3 DPL 3
        step(1,0,0,0, 0,2'd0, 2'b11,1,0,2'd0);   // R3 other kind
        step(1,0,0,0, 0,2'd0, 2'b10,0,0,2'd0);   // R3 16-bit TSS
        step(1,0,0,0, 0,2'd0, 2'b01,1,0,2'd0);   // R2 trap gate exit
        step(0,0,1,0, 1,2'd0, 2'b00,1,0,2'd0);   // R4 iret back to V86
        step(1,0,0,0, 0,2'd0, 2'b10,1,1,2'd3);   // R2 32-bit TSS exit
        step(1,0,0,0, 0,2'd0, 2'b11,0,1,2'd2);   // R11 protected intr to DPL2
        step(0,0,1,0, 1,2'd0, 2'b00,1,0,2'd0);   // R5 iret at cpl2 with VM image
        step(0,0,1,0, 0,2'd0, 2'b00,1,0,2'd0);   // R6 plain iret to cpl0
        step(0,1,1,1, 0,2'd3, 2'b00,1,0,2'd0);   // R10 task beats iret
        step(0,0,1,1, 1,2'd0, 2'b00,1,0,2'd0);   // R10 iret beats popf (cpl3: R5)
        step(0,0,1,0, 0,2'd0, 2'b00,1,0,2'd0);   // R6 back to cpl0
        step(0,0,1,1, 1,2'd0, 2'b00,1,0,2'd0);   // R10 iret enters V86
        step(1,1,1,1, 0,2'd0, 2'b00,1,0,2'd0);   // R10 intr beats all, legal exit
        step(0,1,0,0, 1,2'd0, 2'b00,1,0,2'd0);   // R7 re-enter
        step(1,1,1,1, 0,2'd0, 2'b00,0,0,2'd0);   // R10 intr wins, illegal -> gp

        // constrained random
        for (int n = 0; n < N_RANDOM; n++) begin
            int sel;
            logic i, t, r, p;
            sel = int'($urandom_range(0, 99));
            i = sel < 25; t = (sel >= 20 && sel < 40);
            r = (sel >= 35 && sel < 70); p = (sel >= 65 && sel < 85) || sel >= 97;
            step(i, t, r, p, ($urandom_range(0, 2) != 0), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 2) == 0) ? 2'($urandom_range(0, 3)) : 2'($urandom_range(0, 1)),
                 ($urandom_range(0, 4) != 0), ($urandom_range(0, 4) == 0),
                 ($urandom_range(0, 2) == 0) ? 2'($urandom_range(0, 3)) : 2'd0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule